// File: doc/BRIEF.md
# Parallel NOR Flash Host Controller

This block sits between an on-chip requester and an asynchronous parallel NOR flash bus. It turns three kinds of request into bus activity: a write cycle in byte or word width, a hardware reset pulse, and a wait that lasts until an embedded program or erase has finished. All flash strobes (chip enable, write enable, output enable, reset, bus width select) are active-low outputs decoded from the state register. Every bus time is a parameter counted in clock cycles.

A write request may be tagged as the one that launches an embedded operation. The controller remembers that an operation is in flight until a wait reports completion or a reset cuts it off. This flag picks the recovery time after a reset. A reset that cuts off an operation, including a wait still pending, is reported to the requester with a one-cycle abort pulse, so the requester can issue the operation again.

Completion is found in one of two ways. The first samples the ready/busy pin through a two-stage synchronizer. The second runs back-to-back status reads and compares the status bits of consecutive reads.

Top module: `nor_host_ctrl`

## Requirements
- R1: While write enable is low, chip enable is low and output enable is high. The address and write data stay constant for the whole low phase. At the rising edge of write enable, the bus carries the address and data of the accepted write request.
- R2: In a write, chip enable goes low T_SU cycles before write enable falls. Write enable stays low for exactly T_WP cycles. Chip enable and the data stay driven for T_HD cycles after write enable rises, and then chip enable returns high.
- R3: A word write (req_word=1) sets fl_byte_n=1 and drives both byte lanes (fl_dq_oe=2'b11). A byte write sets fl_byte_n=0, drives only lane 0 (fl_dq_oe=2'b01), and puts zero on the upper lane. The upper lane is never enabled while fl_byte_n is 0.
- R4: req_ready is high only when the controller is idle, and after reset it comes up high with every strobe high. Operation codes are write=0, reset=1, wait=2. Code 3 has no effect. A write request presented while a wait is pending has no effect on the bus.
- R5: A wait with poll_mode=0 ends with a one-cycle resp_done pulse. The pulse is visible exactly 3 clock cycles after fl_ryby rises. No pulse comes while fl_ryby stays low.
- R6: A reset request holds fl_rst_n low for exactly T_RP cycles. During that time chip enable, write enable and output enable are high and no lane is driven.
- R7: After fl_rst_n rises, req_ready returns after max(T_RDY, T_RP+T_RH) - T_RP cycles. T_RDY is T_RDY_BUSY when an embedded operation was in flight at the reset request, and T_RDY_IDLE otherwise. A write with req_launch=1 marks an operation as in flight when it finishes. A completed wait or a reset clears the mark.
- R8: resp_abort pulses for one cycle, in the first cycle of the reset pulse, exactly when a reset is accepted with an embedded operation in flight. resp_abort and resp_done are never high together.
- R9: In polling mode, each status read holds chip enable and output enable low for T_RD cycles, with write enable high and no lane driven. Output enable goes high for at least one cycle between reads. The status is sampled in the last low cycle.
- R10: A polling wait (poll_mode=1) ends with resp_done after the first read whose bit 6 equals bit 6 of the previous read and whose bit 7 equals bit 7 of req_data in the wait request. The first read of a wait never ends it.
- R11: A reset request is also accepted while a wait is pending. That wait then ends without resp_done, and the abort pulse of R8 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| poll_mode | input | 1 | Completion method for a wait: 0 ready pin, 1 status polling |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation: 0 write, 1 reset, 2 wait |
| req_addr | input | AW | Write address, or status read address for a wait |
| req_data | input | DQ_W | Write data; bit 7 is the expected final status bit for a wait |
| req_word | input | 1 | Write width: 1 word, 0 byte |
| req_launch | input | 1 | This write starts an embedded operation |
| req_ready | output | 1 | Idle and able to take any request |
| resp_done | output | 1 | One-cycle pulse: wait completed |
| resp_abort | output | 1 | One-cycle pulse: embedded operation cut off by reset |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DQ_W | Flash data bus, outgoing value |
| fl_dq_oe | output | DQ_W/8 | Per-byte-lane drive enable for the data bus |
| fl_dq_in | input | DQ_W | Flash data bus, incoming value |
| fl_ryby | input | 1 | Flash ready/busy pin, high when ready |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_rst_n | output | 1 | Flash hardware reset, active low |
| fl_byte_n | output | 1 | Bus width select: low for byte, high for word |

## Verification
The bench builds the controller with T_SU=1, T_WP=3, T_HD=1, T_RD=2, T_RP=4, T_RH=3, T_RDY_BUSY=40 and T_RDY_IDLE=6, and an 8-bit address. With these values both recovery branches finish within a few dozen cycles and can be told apart: 36 cycles after an interrupted operation against 3 cycles otherwise. Because T_RDY_IDLE is below T_RP+T_RH, the idle branch is set by the tRH floor and not by the ready time. The short read time lets the bench's flash model run status sequences that keep toggling, hold bit 7 wrong after toggling stops, or are settled from the first read, and count the exact number of reads before completion.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_RESET = 2'd1,
    OP_WAIT  = 2'd2,
    OP_NONE  = 2'd3
  } nor_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR_SU,
    ST_WR_PW,
    ST_WR_HD,
    ST_RST_LO,
    ST_RST_REC,
    ST_WT_PIN,
    ST_RD_ACT,
    ST_RD_GAP
  } nor_state_e;

  // Cycles to spend after the reset pin rises: the ready time counts from the
  // falling edge, but the read recovery time after the rise is a floor.
  function automatic int unsigned rst_after_rise(input int unsigned ready_cyc,
                                                 input int unsigned pulse_cyc,
                                                 input int unsigned rh_cyc);
    int unsigned floor_cyc;
    floor_cyc = pulse_cyc + rh_cyc;
    return ((ready_cyc > floor_cyc) ? ready_cyc : floor_cyc) - pulse_cyc;
  endfunction

  // Status polling verdict for one read against the previous one.
  function automatic logic poll_settled(input logic first_rd,
                                        input logic prev_b6,
                                        input logic cur_b6,
                                        input logic cur_b7,
                                        input logic want_b7);
    return !first_rd && (prev_b6 == cur_b6) && (cur_b7 == want_b7);
  endfunction

endpackage

// File: rtl/nor_tick_cnt.sv
module nor_tick_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/nor_poll_judge.sv
module nor_poll_judge
  import nor_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sample,
  input  logic dq6,
  input  logic dq7,
  input  logic exp7,
  output logic settled
);
  logic first_q;
  logic prev6_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      prev6_q <= 1'b0;
    end else if (start) begin
      first_q <= 1'b1;
    end else if (sample) begin
      first_q <= 1'b0;
      prev6_q <= dq6;
    end
  end

  assign settled = poll_settled(first_q, prev6_q, dq6, dq7, exp7);
endmodule

// File: rtl/nor_lane_drv.sv
module nor_lane_drv #(
  parameter int DQ_W  = 16,
  localparam int LANES = DQ_W / 8
) (
  input  logic             drive,
  input  logic             word,
  input  logic [DQ_W-1:0]  data,
  output logic [DQ_W-1:0]  dq_out,
  output logic [LANES-1:0] dq_oe
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_on;
    assign lane_on = drive && (word || (l == 0));
    assign dq_oe[l] = lane_on;
    assign dq_out[l*8 +: 8] = (word || (l == 0)) ? data[l*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/nor_host_ctrl.sv
module nor_host_ctrl
  import nor_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DQ_W       = 16,
  parameter int T_SU       = 2,
  parameter int T_WP       = 4,
  parameter int T_HD       = 2,
  parameter int T_RD       = 5,
  parameter int T_RP       = 25,
  parameter int T_RH       = 3,
  parameter int T_RDY_BUSY = 1000,
  parameter int T_RDY_IDLE = 25,
  localparam int LANES     = DQ_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_mode,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [DQ_W-1:0]  req_data,
  input  logic             req_word,
  input  logic             req_launch,
  output logic             req_ready,
  output logic             resp_done,
  output logic             resp_abort,
  output logic [AW-1:0]    fl_addr,
  output logic [DQ_W-1:0]  fl_dq_out,
  output logic [LANES-1:0] fl_dq_oe,
  input  logic [DQ_W-1:0]  fl_dq_in,
  input  logic             fl_ryby,
  output logic             fl_ce_n,
  output logic             fl_we_n,
  output logic             fl_oe_n,
  output logic             fl_rst_n,
  output logic             fl_byte_n
);
  localparam int unsigned REC_BUSY = rst_after_rise(T_RDY_BUSY, T_RP, T_RH);
  localparam int unsigned REC_IDLE = rst_after_rise(T_RDY_IDLE, T_RP, T_RH);
  localparam int CW = $clog2(T_RDY_BUSY + T_RDY_IDLE + T_RP + T_RH + T_SU
                             + T_WP + T_HD + T_RD + 2) + 1;

  nor_state_e st_q, st_d;

  logic          tmr_ld;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;

  logic [AW-1:0]   addr_q;
  logic [DQ_W-1:0] data_q;
  logic            word_q;
  logic            launch_q;
  logic            exp7_q;
  logic            emb_q;
  logic            rst_emb_q;
  logic            done_q;
  logic            abort_q;
  logic [1:0]      ryby_sync_q;

  // Named internal events
  logic is_idle, wait_active, ryby_s;
  logic ev_acc_wr, ev_acc_wait, ev_acc_rst;
  logic poll_sample, poll_ok, ev_done, ev_abort, wr_finish;

  assign is_idle     = (st_q == ST_IDLE);
  assign wait_active = (st_q == ST_WT_PIN) || (st_q == ST_RD_ACT) || (st_q == ST_RD_GAP);
  assign ryby_s      = ryby_sync_q[1];

  assign ev_acc_wr   = req_valid && is_idle && (req_op == OP_WRITE);
  assign ev_acc_wait = req_valid && is_idle && (req_op == OP_WAIT);
  assign ev_acc_rst  = req_valid && (req_op == OP_RESET) && (is_idle || wait_active);

  assign poll_sample = (st_q == ST_RD_ACT) && tmr_zero;
  assign wr_finish   = (st_q == ST_WR_HD) && tmr_zero;
  assign ev_done     = !ev_acc_rst &&
                       (((st_q == ST_WT_PIN) && ryby_s) || (poll_sample && poll_ok));
  assign ev_abort    = ev_acc_rst && emb_q;

  // Next state and timer loads
  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (ev_acc_wr) begin
          st_d = ST_WR_SU;  tmr_ld = 1'b1; tmr_val = CW'(T_SU - 1);
        end else if (ev_acc_rst) begin
          st_d = ST_RST_LO; tmr_ld = 1'b1; tmr_val = CW'(T_RP - 1);
        end else if (ev_acc_wait) begin
          if (poll_mode) begin
            st_d = ST_RD_ACT; tmr_ld = 1'b1; tmr_val = CW'(T_RD - 1);
          end else begin
            st_d = ST_WT_PIN;
          end
        end
      end
      ST_WR_SU: if (tmr_zero) begin
        st_d = ST_WR_PW; tmr_ld = 1'b1; tmr_val = CW'(T_WP - 1);
      end
      ST_WR_PW: if (tmr_zero) begin
        st_d = ST_WR_HD; tmr_ld = 1'b1; tmr_val = CW'(T_HD - 1);
      end
      ST_WR_HD: if (tmr_zero) st_d = ST_IDLE;
      ST_RST_LO: if (tmr_zero) begin
        st_d = ST_RST_REC; tmr_ld = 1'b1;
        tmr_val = rst_emb_q ? CW'(REC_BUSY - 1) : CW'(REC_IDLE - 1);
      end
      ST_RST_REC: if (tmr_zero) st_d = ST_IDLE;
      ST_WT_PIN: begin
        if (ev_acc_rst) begin
          st_d = ST_RST_LO; tmr_ld = 1'b1; tmr_val = CW'(T_RP - 1);
        end else if (ryby_s) begin
          st_d = ST_IDLE;
        end
      end
      ST_RD_ACT: begin
        if (ev_acc_rst) begin
          st_d = ST_RST_LO; tmr_ld = 1'b1; tmr_val = CW'(T_RP - 1);
        end else if (tmr_zero) begin
          st_d = poll_ok ? ST_IDLE : ST_RD_GAP;
        end
      end
      ST_RD_GAP: begin
        if (ev_acc_rst) begin
          st_d = ST_RST_LO; tmr_ld = 1'b1; tmr_val = CW'(T_RP - 1);
        end else begin
          st_d = ST_RD_ACT; tmr_ld = 1'b1; tmr_val = CW'(T_RD - 1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      data_q      <= '0;
      word_q      <= 1'b1;
      launch_q    <= 1'b0;
      exp7_q      <= 1'b0;
      emb_q       <= 1'b0;
      rst_emb_q   <= 1'b0;
      done_q      <= 1'b0;
      abort_q     <= 1'b0;
      ryby_sync_q <= 2'b00;
    end else begin
      st_q        <= st_d;
      done_q      <= ev_done;
      abort_q     <= ev_abort;
      ryby_sync_q <= {ryby_sync_q[0], fl_ryby};
      if (ev_acc_wr || ev_acc_wait) addr_q <= req_addr;
      if (ev_acc_wr) begin
        data_q   <= req_data;
        word_q   <= req_word;
        launch_q <= req_launch;
      end
      if (ev_acc_wait) exp7_q <= req_data[7];
      if (ev_acc_rst) rst_emb_q <= emb_q;
      if (ev_acc_rst || ev_done)       emb_q <= 1'b0;
      else if (wr_finish && launch_q)  emb_q <= 1'b1;
    end
  end

  nor_tick_cnt #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  nor_poll_judge u_judge (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (ev_acc_wait),
    .sample  (poll_sample),
    .dq6     (fl_dq_in[6]),
    .dq7     (fl_dq_in[7]),
    .exp7    (exp7_q),
    .settled (poll_ok)
  );

  logic wr_drive;
  assign wr_drive = (st_q == ST_WR_SU) || (st_q == ST_WR_PW) || (st_q == ST_WR_HD);

  nor_lane_drv #(.DQ_W(DQ_W)) u_lanes (
    .drive  (wr_drive),
    .word   (word_q),
    .data   (data_q),
    .dq_out (fl_dq_out),
    .dq_oe  (fl_dq_oe)
  );

  assign fl_addr    = addr_q;
  assign fl_ce_n    = !(wr_drive || (st_q == ST_RD_ACT));
  assign fl_we_n    = (st_q != ST_WR_PW);
  assign fl_oe_n    = (st_q != ST_RD_ACT);
  assign fl_rst_n   = (st_q != ST_RST_LO);
  assign fl_byte_n  = word_q;
  assign req_ready  = is_idle;
  assign resp_done  = done_q;
  assign resp_abort = abort_q;
endmodule

// File: rtl/nor_host_ctrl_chk.sv
module nor_host_ctrl_chk #(
  parameter int AW    = 20,
  parameter int DQ_W  = 16,
  parameter int LANES = 2,
  parameter int T_WP  = 4,
  parameter int T_RP  = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fl_ce_n,
  input logic             fl_we_n,
  input logic             fl_oe_n,
  input logic             fl_rst_n,
  input logic             fl_byte_n,
  input logic [AW-1:0]    fl_addr,
  input logic [DQ_W-1:0]  fl_dq_out,
  input logic [LANES-1:0] fl_dq_oe,
  input logic             req_ready,
  input logic             resp_done,
  input logic             resp_abort,
  input logic             wait_active
);
  logic [15:0] we_lo_cnt;
  logic [15:0] rst_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt  <= '0;
      rst_lo_cnt <= '0;
    end else begin
      we_lo_cnt  <= fl_we_n  ? 16'd0 : we_lo_cnt + 16'd1;
      rst_lo_cnt <= fl_rst_n ? 16'd0 : rst_lo_cnt + 16'd1;
    end
  end

  // R1
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n));

  // R1
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  // R2
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (we_lo_cnt == 16'(T_WP)));

  // R3
  lane_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_dq_oe >> 1) != '0) |-> fl_byte_n);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && fl_rst_n && fl_we_n && fl_oe_n));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  // R6
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_rst_n |-> (fl_ce_n && fl_we_n && fl_oe_n && (fl_dq_oe == '0)));

  // R6
  rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_rst_n) |-> (rst_lo_cnt == 16'(T_RP)));

  // R8
  abort_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_abort |-> (!fl_rst_n && !resp_done));

  // R9
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (!fl_ce_n && fl_we_n && (fl_dq_oe == '0)));

  // R11
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |-> $past(wait_active));
endmodule

bind nor_host_ctrl nor_host_ctrl_chk #(
  .AW    (AW),
  .DQ_W  (DQ_W),
  .LANES (LANES),
  .T_WP  (T_WP),
  .T_RP  (T_RP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fl_ce_n     (fl_ce_n),
  .fl_we_n     (fl_we_n),
  .fl_oe_n     (fl_oe_n),
  .fl_rst_n    (fl_rst_n),
  .fl_byte_n   (fl_byte_n),
  .fl_addr     (fl_addr),
  .fl_dq_out   (fl_dq_out),
  .fl_dq_oe    (fl_dq_oe),
  .req_ready   (req_ready),
  .resp_done   (resp_done),
  .resp_abort  (resp_abort),
  .wait_active (wait_active)
);

// File: tb/tb_nor_host_ctrl.sv
module tb_nor_host_ctrl;
  localparam int AW = 8, DQ_W = 16, LANES = 2;
  localparam int T_SU = 1, T_WP = 3, T_HD = 1, T_RD = 2;
  localparam int T_RP = 4, T_RH = 3, T_RDY_BUSY = 40, T_RDY_IDLE = 6;
  localparam int EV_DONE = 1, EV_ABORT = 2;

  logic clk = 0, rst_n = 0;
  logic poll_mode = 0, req_valid = 0, req_word = 0, req_launch = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DQ_W-1:0] req_data = 0;
  logic req_ready, resp_done, resp_abort;
  logic [AW-1:0] fl_addr;
  logic [DQ_W-1:0] fl_dq_out;
  logic [LANES-1:0] fl_dq_oe;
  logic [DQ_W-1:0] fl_dq_in = 16'h0000;
  logic fl_ryby = 1;
  logic fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n, fl_byte_n;

  always #10 clk = ~clk;

  nor_host_ctrl #(.AW(AW), .DQ_W(DQ_W), .T_SU(T_SU), .T_WP(T_WP), .T_HD(T_HD),
    .T_RD(T_RD), .T_RP(T_RP), .T_RH(T_RH), .T_RDY_BUSY(T_RDY_BUSY),
    .T_RDY_IDLE(T_RDY_IDLE)) dut (.*);

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int rec_exp(input int ready);
    int lo_plus;
    lo_plus = T_RP + T_RH;
    if (ready < lo_plus) return T_RH;
    return ready - T_RP;
  endfunction

  // Scoreboard queues
  logic [AW-1:0]   wq_addr[$];
  logic [DQ_W-1:0] wq_data[$];
  logic            wq_word[$];
  int              evq[$];

  int we_falls = 0, oe_falls = 0, n_done = 0, n_abort = 0;

  // Flash status model for polling
  int tog_left = 0, bad_left = 0;
  logic m_exp = 0;
  initial forever begin
    @(negedge fl_oe_n);
    if (tog_left > 0) begin
      fl_dq_in[6] = ~fl_dq_in[6];
      fl_dq_in[7] = ~m_exp;
      tog_left--;
    end else if (bad_left > 0) begin
      fl_dq_in[7] = ~m_exp;
      bad_left--;
    end else begin
      fl_dq_in[7] = m_exp;
    end
  end

  // Monitor
  initial begin
    int su_cnt, we_cnt, hd_cnt, rd_cnt;
    bit seen_we, prev_we_lo, prev_oe_lo, rd_bad;
    su_cnt = 0; we_cnt = 0; hd_cnt = 0; rd_cnt = 0;
    seen_we = 0; prev_we_lo = 0; prev_oe_lo = 0; rd_bad = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!fl_we_n) begin
          if (!prev_we_lo) we_falls++;
          we_cnt++;
          seen_we = 1;
        end else if (seen_we && !fl_ce_n) begin
          if (prev_we_lo) begin
            logic [DQ_W-1:0] ed;
            check(su_cnt == T_SU, "R2", "CE-to-WE setup", su_cnt, T_SU);
            check(we_cnt == T_WP, "R2", "WE low width", we_cnt, T_WP);
            if (wq_addr.size() == 0) begin
              check(0, "R1", "unexpected write cycle", fl_addr, 0);
            end else begin
              logic [AW-1:0] ea;
              logic ew;
              ea = wq_addr.pop_front();
              ed = wq_data.pop_front();
              ew = wq_word.pop_front();
              if (!ew) ed = {8'h00, ed[7:0]};
              check(fl_addr == ea, "R1", "write address", fl_addr, ea);
              check(fl_dq_out == ed, "R1", "write data", fl_dq_out, ed);
              check(fl_byte_n == ew, "R3", "byte select", fl_byte_n, ew);
              check(fl_dq_oe == (ew ? 2'b11 : 2'b01), "R3", "lane enables",
                    fl_dq_oe, ew ? 2'b11 : 2'b01);
            end
          end
          hd_cnt++;
        end else if (!fl_ce_n && fl_oe_n) begin
          su_cnt++;
        end
        if (fl_ce_n) begin
          if (seen_we) check(hd_cnt == T_HD, "R2", "hold after WE", hd_cnt, T_HD);
          seen_we = 0; su_cnt = 0; we_cnt = 0; hd_cnt = 0;
        end
        prev_we_lo = !fl_we_n;

        if (!fl_oe_n) begin
          if (!prev_oe_lo) oe_falls++;
          rd_cnt++;
          if (fl_ce_n || !fl_we_n || fl_dq_oe != 0) rd_bad = 1;
        end else if (prev_oe_lo) begin
          check(rd_cnt == T_RD && !rd_bad, "R9", "read strobe width/quiet", rd_cnt, T_RD);
          rd_cnt = 0; rd_bad = 0;
        end
        prev_oe_lo = !fl_oe_n;

        if (resp_done || resp_abort) begin
          int k, e;
          k = resp_done ? EV_DONE : EV_ABORT;
          if (resp_done) n_done++; else n_abort++;
          e = (evq.size() != 0) ? evq.pop_front() : 0;
          check(k == e, "R8", "response event", k, e);
        end
      end
    end
  end

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [DQ_W-1:0] d, input logic w, input logic l);
    @(negedge clk);
    while (!req_ready && op != 2'd1) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    req_word = w; req_launch = l;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DQ_W-1:0] d,
                          input logic w, input logic l);
    wq_addr.push_back(a); wq_data.push_back(d); wq_word.push_back(w);
    send(2'd0, a, d, w, l);
    wait_idle();
  endtask

  task automatic do_reset(input bit busy, input string req);
    int lo, rec, ab0, exp_rec;
    ab0 = n_abort;
    if (busy) evq.push_back(EV_ABORT);
    send(2'd1, '0, '0, 1'b1, 1'b0);
    lo = 0;
    while (!fl_rst_n) begin lo++; @(negedge clk); end
    rec = 0;
    while (!req_ready) begin rec++; @(negedge clk); end
    exp_rec = rec_exp(busy ? T_RDY_BUSY : T_RDY_IDLE);
    check(lo == T_RP, "R6", "reset pulse width", lo, T_RP);
    check(rec == exp_rec, req, "recovery cycles", rec, exp_rec);
    check(n_abort - ab0 == (busy ? 1 : 0), "R8", "abort count", n_abort - ab0, busy);
  endtask

  task automatic do_poll(input int tog, input int bad, input logic ex, input int exp_reads);
    int f0;
    tog_left = tog; bad_left = bad; m_exp = ex;
    fl_dq_in[7] = ~ex;
    poll_mode = 1;
    evq.push_back(EV_DONE);
    f0 = oe_falls;
    send(2'd2, 8'h55, {8'h00, ex, 7'h00}, 1'b1, 1'b0);
    while (!resp_done) @(negedge clk);
    check(oe_falls - f0 == exp_reads, "R10", "status reads before done",
          oe_falls - f0, exp_reads);
    wait_idle();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung (actual not finished, expected finished)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int d0, w0, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4 reset state
    check(req_ready && fl_ce_n && fl_we_n && fl_oe_n && fl_rst_n &&
          fl_dq_oe == 0 && !resp_done && !resp_abort, "R4", "reset state",
          {req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n}, 5'h1f);

    // R1 R2 R3 word and byte writes
    do_write(8'h3A, 16'hA55A, 1'b1, 1'b0);
    do_write(8'h81, 16'h12C7, 1'b0, 1'b0);
    do_write(8'hFE, 16'h0F0F, 1'b1, 1'b0);

    // R4 op code 3 has no effect
    w0 = we_falls;
    send(2'd3, 8'h11, 16'hFFFF, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    check(we_falls == w0 && req_ready && fl_rst_n && fl_oe_n, "R4", "op 3 ignored",
          we_falls - w0, 0);

    // R7 idle recovery (floor by T_RH), R8 no abort
    do_reset(0, "R7");

    // R7 busy recovery after a launching write, R8 abort
    do_write(8'h10, 16'h00A0, 1'b1, 1'b1);
    do_reset(1, "R7");

    // R5 pin wait with R4 ignored write
    poll_mode = 0; fl_ryby = 0;
    evq.push_back(EV_DONE);
    d0 = n_done;
    send(2'd2, 8'h20, 16'h0000, 1'b1, 1'b0);
    check(!req_ready, "R4", "ready low during wait", req_ready, 0);
    w0 = we_falls;
    req_valid = 1; req_op = 2'd0; req_addr = 8'h77; req_data = 16'hBEEF;
    repeat (3) @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    check(we_falls == w0 && fl_we_n, "R4", "write during wait ignored", we_falls - w0, 0);
    check(n_done == d0, "R5", "no done while busy", n_done - d0, 0);
    fl_ryby = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!resp_done && n < 20);
    check(n == 3, "R5", "done latency after ready pin", n, 3);
    @(negedge clk);
    check(!resp_done, "R5", "done is one cycle", resp_done, 0);
    wait_idle();

    // R10 polling: toggling then settled; done clears in-flight mark (R7)
    do_write(8'h30, 16'h0080, 1'b1, 1'b1);
    do_poll(3, 0, 1'b1, 4);
    do_reset(0, "R7");
    // R10 settled from the start: never done on first read
    do_poll(0, 0, 1'b0, 2);
    // R10 toggling stops but bit 7 still wrong for two reads
    do_poll(1, 2, 1'b1, 4);

    // R11 reset during a pending wait
    do_write(8'h44, 16'h0033, 1'b0, 1'b1);
    poll_mode = 0; fl_ryby = 0;
    d0 = n_done;
    send(2'd2, 8'h44, 16'h0000, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    do_reset(1, "R11");
    repeat (5) @(negedge clk);
    check(n_done == d0, "R11", "no done for cut-off wait", n_done - d0, 0);
    fl_ryby = 1;
    repeat (5) @(negedge clk);

    check(evq.size() == 0 && wq_addr.size() == 0, "R1", "scoreboard drained",
          evq.size() + wq_addr.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule